// File: doc/BRIEF.md
# Interrupt Enable Mask Status Unit

This block is the interrupt-control register group of a peripheral. Raw event pulses from elsewhere in the peripheral are caught in a sticky status register. Software clears a status bit by writing a one to it. An enable mask decides which caught events reach the single interrupt line. The mask has no direct write path. Software sets mask bits through a write-1-to-set enable offset and clears them through a write-1-to-clear disable offset. Both of those offsets are write-only and read back as zero.

A separate live view returns the present level of every condition, whatever the mask holds. Software can therefore poll a condition it has chosen not to take as an interrupt. Access is through one plain register port that carries at most one read or one write per cycle. How event bits are assigned to positions is left to the surrounding peripheral.

Offsets (byte addresses on `reg_addr`):

| Offset | Name | Access |
|---|---|---|
| 0x00 | enable | write only |
| 0x04 | disable | write only |
| 0x08 | mask | read only |
| 0x0C | status | read, and write-1-to-clear |
| 0x10 | live | read only |

Top module: `irq_mask_status_unit`

## Requirements
- R1: While reset is low and after it is released, the interrupt output is 0, read data is 0, and both the mask and the status read as 0.
- R2: A write to offset 0x00 sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to offset 0x04 clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: A read of offset 0x00 or 0x04 returns 0, whatever the mask holds.
- R5: A 1 on bit i of `evt_pulse` sets status bit i. A status bit stays set until it is cleared by a write.
- R6: A write to offset 0x0C clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R7: If an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R8: `irq` is a register. In each cycle it equals the OR over all bits of status AND mask, taken as they stood one cycle earlier.
- R9: A read of offset 0x10 returns `evt_level` as sampled in the read cycle, independent of the mask.
- R10: Read-data bits at positions NUM_EVT and above always read 0. Write-data bits at those positions have no effect.
- R11: Writes to offsets 0x08 and 0x10, and to any unlisted offset, change neither the mask nor the status.
- R12: Read data is registered. It updates on the clock edge that samples `reg_rd` and holds while `reg_rd` is low. A read of an unlisted offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| evt_pulse | input | NUM_EVT | Raw event pulses that set status bits |
| evt_level | input | NUM_EVT | Live condition levels for the live view |
| irq | output | 1 | Registered interrupt request |

## Verification
A write or an event pulse sampled on clock edge k changes the mask or status after edge k. Because `irq` is registered, it reflects that change only after edge k+1, two edges after the stimulus. Read data is due after the edge that samples the read strobe, and it carries the register values from before that edge. The bench drives every input on the falling edge and advances its own model at the rising edge, using the same inputs. It then compares `irq` and `reg_rdata` on the next falling edge, so each result is checked in exactly the cycle it becomes due.

// File: rtl/imsu_pkg.sv
package imsu_pkg;

   // byte offsets of the register group
   localparam logic [7:0] OFS_ENABLE  = 8'h00;
   localparam logic [7:0] OFS_DISABLE = 8'h04;
   localparam logic [7:0] OFS_MASK    = 8'h08;
   localparam logic [7:0] OFS_STATUS  = 8'h0C;
   localparam logic [7:0] OFS_LIVE    = 8'h10;

   // minimum address width that reaches the highest offset
   localparam int MIN_ADDR_W = 5;

   typedef enum logic [2:0] {
      SEL_ZERO = 3'd0,
      SEL_MASK = 3'd1,
      SEL_STAT = 3'd2,
      SEL_LIVE = 3'd3
   } rd_sel_e;

   typedef struct packed {
      logic    set_we;
      logic    clr_we;
      logic    ack_we;
      logic    rd;
      rd_sel_e sel;
   } imsu_cmd_t;

endpackage

// File: rtl/imsu_decode.sv
module imsu_decode
   import imsu_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   output imsu_cmd_t         cmd
);

   logic hit_ena, hit_dis, hit_mask, hit_stat, hit_live;

   assign hit_ena  = (reg_addr == ADDR_W'(OFS_ENABLE));
   assign hit_dis  = (reg_addr == ADDR_W'(OFS_DISABLE));
   assign hit_mask = (reg_addr == ADDR_W'(OFS_MASK));
   assign hit_stat = (reg_addr == ADDR_W'(OFS_STATUS));
   assign hit_live = (reg_addr == ADDR_W'(OFS_LIVE));

   always_comb begin
      cmd.set_we = reg_wr & hit_ena;
      cmd.clr_we = reg_wr & hit_dis;
      cmd.ack_we = reg_wr & hit_stat;
      cmd.rd     = reg_rd;
      if (hit_mask)      cmd.sel = SEL_MASK;
      else if (hit_stat) cmd.sel = SEL_STAT;
      else if (hit_live) cmd.sel = SEL_LIVE;
      else               cmd.sel = SEL_ZERO;
   end

   // a single access port never produces two write strobes at once (R11)
   assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd.set_we, cmd.clr_we, cmd.ack_we}));

endmodule

// File: rtl/imsu_mask_bank.sv
module imsu_mask_bank #(
   parameter int NUM_EVT = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic [NUM_EVT-1:0] wbits,
   output logic [NUM_EVT-1:0] mask_q
);

   logic [NUM_EVT-1:0] mask_d;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      // a disable request takes priority over an enable request on the same bit
      assign mask_d[i] = (clr_we && wbits[i]) ? 1'b0 :
                         (set_we && wbits[i]) ? 1'b1 : mask_q[i];

      assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (set_we && wbits[i] && !clr_we) |=> mask_q[i]);

      assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && wbits[i]) |=> !mask_q[i]);

      assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !(wbits[i] && (set_we || clr_we)) |=> $stable(mask_q[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end

endmodule

// File: rtl/imsu_status_bank.sv
module imsu_status_bank #(
   parameter int NUM_EVT = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ack_we,
   input  logic [NUM_EVT-1:0] wbits,
   input  logic [NUM_EVT-1:0] evt_pulse,
   output logic [NUM_EVT-1:0] stat_q
);

   logic [NUM_EVT-1:0] stat_d;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      // a new event outranks a clearing write landing in the same cycle
      assign stat_d[i] = evt_pulse[i] | (stat_q[i] & ~(ack_we & wbits[i]));

      assert_stat_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
         evt_pulse[i] |=> stat_q[i]);

      assert_stat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_we && wbits[i] && !evt_pulse[i]) |=> !stat_q[i]);

      assert_stat_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[i] && !(ack_we && wbits[i])) |=> stat_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

endmodule

// File: rtl/imsu_irq_gen.sv
module imsu_irq_gen #(
   parameter int NUM_EVT = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] stat_q,
   input  logic [NUM_EVT-1:0] mask_q,
   output logic               irq
);

   logic [NUM_EVT-1:0] pending;

   assign pending = stat_q & mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |pending;
   end

   assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (irq == $past(|(stat_q & mask_q))));

endmodule

// File: rtl/irq_mask_status_unit.sv
module irq_mask_status_unit
   import imsu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_EVT = 13,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic [NUM_EVT-1:0] evt_level,
   output logic               irq
);

   // elaboration-time parameter checks
   if (NUM_EVT < 1 || NUM_EVT > DATA_W) begin : g_bad_evt
      $error("NUM_EVT must lie between 1 and DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the offset map");
   end

   imsu_cmd_t          cmd;
   logic [NUM_EVT-1:0] wbits;
   logic [NUM_EVT-1:0] mask_q;
   logic [NUM_EVT-1:0] stat_q;
   logic [DATA_W-1:0]  rd_next;

   // only the valid field of the write data is used (R10)
   assign wbits = reg_wdata[NUM_EVT-1:0];
   if (NUM_EVT < DATA_W) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_EVT];
   end

   imsu_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_addr (reg_addr),
      .cmd      (cmd)
   );

   imsu_mask_bank #(.NUM_EVT(NUM_EVT)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (cmd.set_we),
      .clr_we (cmd.clr_we),
      .wbits  (wbits),
      .mask_q (mask_q)
   );

   imsu_status_bank #(.NUM_EVT(NUM_EVT)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_we    (cmd.ack_we),
      .wbits     (wbits),
      .evt_pulse (evt_pulse),
      .stat_q    (stat_q)
   );

   imsu_irq_gen #(.NUM_EVT(NUM_EVT)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_q (stat_q),
      .mask_q (mask_q),
      .irq    (irq)
   );

   always_comb begin
      unique case (cmd.sel)
         SEL_MASK: rd_next = DATA_W'(mask_q);
         SEL_STAT: rd_next = DATA_W'(stat_q);
         SEL_LIVE: rd_next = DATA_W'(evt_level);
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (cmd.rd) reg_rdata <= rd_next;
   end

   assert_wo_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == ADDR_W'(OFS_ENABLE) || reg_addr == ADDR_W'(OFS_DISABLE)))
      |=> (reg_rdata == '0));

   assert_live_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(OFS_LIVE)) |=> (reg_rdata == DATA_W'($past(evt_level))));

   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   if (NUM_EVT < DATA_W) begin : g_upper_chk
      assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
         reg_rdata[DATA_W-1:NUM_EVT] == '0);
   end

endmodule

// File: tb/irq_mask_status_unit_tb_top.sv
module irq_mask_status_unit_tb_top;

   localparam int DW = 32;
   localparam int NE = 13;
   localparam int AW = 8;
   localparam logic [DW-1:0] VM = (DW'(1) << NE) - 1;

   localparam logic [7:0] A_ENA  = 8'h00;
   localparam logic [7:0] A_DIS  = 8'h04;
   localparam logic [7:0] A_MASK = 8'h08;
   localparam logic [7:0] A_STAT = 8'h0C;
   localparam logic [7:0] A_LIVE = 8'h10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_wr, reg_rd;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata;
   logic [DW-1:0] reg_rdata;
   logic [NE-1:0] evt_pulse, evt_level;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // bench model
   logic [DW-1:0] m_mask, m_stat, m_rd;
   logic          m_irq;

   always #10 clk = ~clk;

   irq_mask_status_unit #(.DATA_W(DW), .NUM_EVT(NE), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_pulse(evt_pulse), .evt_level(evt_level), .irq(irq)
   );

   function automatic logic [DW-1:0] read_val(logic [7:0] a, logic [DW-1:0] mk,
                                              logic [DW-1:0] st, logic [NE-1:0] lv);
      case (a)
         A_MASK:  return mk & VM;
         A_STAT:  return st & VM;
         A_LIVE:  return DW'(lv);
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(logic [7:0] a);
      case (a)
         A_ENA, A_DIS: return "R4";
         A_MASK:       return "R2";
         A_STAT:       return "R5";
         A_LIVE:       return "R9";
         default:      return "R12";
      endcase
   endfunction

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one cycle: drive after falling edge, model at rising edge, check at next falling edge
   task automatic step(bit wr, bit rd, logic [7:0] a, logic [DW-1:0] wd,
                       logic [NE-1:0] pu, logic [NE-1:0] lv, string tag);
      logic [DW-1:0] nm, ns, nr;
      logic          ni;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
      evt_pulse = pu; evt_level = lv;
      nm = m_mask;
      if (wr && a == A_ENA) nm = nm | (wd & VM);
      if (wr && a == A_DIS) nm = nm & ~wd;
      ns = m_stat;
      if (wr && a == A_STAT) ns = ns & ~wd;
      ns = (ns | DW'(pu)) & VM;
      ni = |(m_stat & m_mask);
      nr = rd ? read_val(a, m_mask, m_stat, lv) : m_rd;
      @(posedge clk);
      m_mask = nm & VM; m_stat = ns; m_irq = ni; m_rd = nr;
      @(negedge clk);
      chk("R8", DW'(irq), DW'(m_irq));
      chk(tag, reg_rdata, m_rd);
   endtask

   task automatic rd_reg(logic [7:0] a, string tag);
      step(0, 1, a, '0, '0, '0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed_ok;
      seed_ok = $urandom(32'h5EED_0013);
      rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
      evt_pulse = '0; evt_level = '0;
      m_mask = '0; m_stat = '0; m_rd = '0; m_irq = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs during reset
      chk("R1", DW'(irq), '0);
      chk("R1", reg_rdata, '0);
      rst_n = 1;
      rd_reg(A_MASK, "R1");
      rd_reg(A_STAT, "R1");

      // R2 / R10: enable all ones, only valid field lands
      step(1, 0, A_ENA, '1, '0, '0, "R2");
      rd_reg(A_MASK, "R10");
      // R4: write-only offsets read zero with the mask full
      rd_reg(A_ENA, "R4");
      rd_reg(A_DIS, "R4");
      // R3: clear some bits, zeros untouched
      step(1, 0, A_DIS, 32'h0000_00F0, '0, '0, "R3");
      rd_reg(A_MASK, "R3");
      // R2: set one bit only
      step(1, 0, A_DIS, '1, '0, '0, "R3");
      step(1, 0, A_ENA, 32'h0000_0008, '0, '0, "R2");
      rd_reg(A_MASK, "R2");

      // R5 / R8: pulse a masked-off bit then an enabled bit
      step(0, 0, A_LIVE, '0, 13'h0001, '0, "R5");
      step(0, 0, A_LIVE, '0, '0, '0, "R8");
      chk("R8", DW'(irq), '0);
      step(0, 0, A_LIVE, '0, 13'h0008, '0, "R5");
      step(0, 0, A_LIVE, '0, '0, '0, "R8");
      chk("R8", DW'(irq), 32'd1);
      rd_reg(A_STAT, "R5");
      // R6: clear bit 0 only, bit 3 stays
      step(1, 0, A_STAT, 32'h0000_0001, '0, '0, "R6");
      rd_reg(A_STAT, "R6");
      // R7: event and clear on same bit
      step(1, 0, A_STAT, 32'h0000_0008, 13'h0008, '0, "R7");
      rd_reg(A_STAT, "R7");
      step(1, 0, A_STAT, '1, '0, '0, "R6");
      step(0, 0, A_LIVE, '0, '0, '0, "R8");
      chk("R8", DW'(irq), '0);
      // R9: live view with mask partly off
      rd_reg(A_LIVE, "R9");
      step(0, 1, A_LIVE, '0, '0, 13'h1ABC, "R9");
      // R11: writes to read-only and unlisted offsets
      step(1, 0, A_MASK, '1, '0, '0, "R11");
      step(1, 0, A_LIVE, '1, '0, '0, "R11");
      step(1, 0, 8'h3C, '1, '0, '0, "R11");
      rd_reg(A_MASK, "R11");
      rd_reg(A_STAT, "R11");
      // R12: unlisted read returns zero, rdata holds without a read
      rd_reg(8'h14, "R12");
      step(0, 1, A_LIVE, '0, '0, 13'h0FFF, "R12");
      step(0, 0, A_LIVE, '0, '0, 13'h0001, "R12");
      step(0, 0, A_MASK, '0, '0, '0, "R12");

      // constrained random traffic
      for (int k = 0; k < 3000; k++) begin
         logic [7:0]    a;
         logic [2:0]    pick;
         bit            wr, rd;
         logic [DW-1:0] wd;
         logic [NE-1:0] pu;
         pick = 3'($urandom % 7);
         case (pick)
            3'd0: a = A_ENA;
            3'd1: a = A_DIS;
            3'd2: a = A_MASK;
            3'd3: a = A_STAT;
            3'd4: a = A_LIVE;
            3'd5: a = 8'h14;
            default: a = 8'h3C;
         endcase
         wr = ($urandom % 3) == 0;
         rd = !wr && (($urandom % 2) == 0);
         wd = $urandom & $urandom;
         pu = NE'($urandom & $urandom & $urandom);
         step(wr, rd, a, wd, pu, NE'($urandom), rd ? tag_of(a) : "R12");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule